// File: doc/BRIEF.md
# Security Module Locality Control Register Bank

This block holds the arbitration and command state of a command-response-buffer security module that several localities share. Software reaches it through a 32-bit register port. Each access carries a locality index and a dword-aligned byte offset inside that locality's register window. Status words are not stored. They are built on every read from the active-locality register, the request and seized bitmaps, the establishment flag and the command state machine.

Control writes request, relinquish or seize the module, or clear the establishment flag. Each write takes effect only under the locality-priority and state conditions listed below. Writes from the active locality move the command state machine between idle, ready, reception, execution, cancel and completion. An external execution engine reports completion and fatal errors through two input pulses, and it observes the current state on an output. The data buffer storage lives outside this block. Here the buffer region only marks the start of command reception, and reads of it return all ones.

Top module: `crb_loc_regs`

## Requirements
- R1: After reset, no locality is active, both bitmaps are clear, the command state is idle (code 0), and the establishment flag is set. Locality state (offset 0x00) reads 0x81 and control status (0x44) reads 0x2.
- R2: Locality state bit 7 is always 1. When a locality is active, bit 1 is 1 and bits 4:2 hold the active index. When none is active, bits 4:1 are 0.
- R3: Locality state bit 0 mirrors the establishment flag. A write with bit 3 set to locality control (0x08) clears the flag only when the active locality is 3 or higher and the command state is idle or ready. Nothing sets the flag again except reset.
- R4: Locality status (0x0C) bit 0 is 1 only when the reading locality is the active one. Bit 1 is 1 when the reading locality's bit in the seized bitmap is set.
- R5: A locality control write with bit 0 set sets the writer's request bit if it is clear, and it grants the writer when no locality is active. A write that finds the bit already set has no effect.
- R6: A locality control write with bit 1 set acts only when the writer's request bit is set. It clears that bit and the writer's seized bit. If the writer was active, the highest-numbered remaining requester becomes active, or none if there is no requester.
- R7: A locality control write with bit 2 set takes effect only when a locality is active and the writer's index is greater than the active index. The old active locality's seized bit is set, and the writer becomes active with its request bit set. Bit order within one write is seize, then request, then relinquish.
- R8: Control status (0x44) reads 0x1 in the fatal state, 0x2 in idle, and 0 otherwise. Cancel (0x48) reads 1 only in the cancel state. Start (0x4C) reads 1 only in execution.
- R9: Command writes are accepted only from the active locality. Each transition takes one of these paths:
  - control request (0x40) bit 0 moves idle or completion to ready (1);
  - control request bit 1 moves ready, reception or completion to idle;
  - a write at offset 0x80 or above moves ready to reception (2);
  - start bit 0 moves ready or reception to execution (3);
  - cancel bit 0 moves execution to cancel (5);
  - the done pulse moves execution or cancel to completion (4).
- R10: The fatal pulse moves any state to fatal (6), which holds until reset.
- R11: The command address (0x5C low, 0x60 high) and the response address (0x68 low, 0x6C high) read as halves of base + locality × window + 0x80. The command size (0x58) and response size (0x64) read the buffer size.
- R12: Interface ID (0x30) reads type 1 in bits 3:0, version 1 in bits 7:4, size code 3 in bits 10:9, bit 14, select 1 in bits 18:17, lock bit 19 and the revision in bits 31:24. Bit 8 is set only while the capability input is high. Offset 0x34 reads the vendor ID in bits 15:0 and the device ID in bits 31:16.
- R13: Locality control and control request read 0. Unmapped offsets, the buffer region, and localities at or above the locality count read all ones, and writes to them change nothing.
- R14: Read data and its valid flag appear on the clock edge after the read strobe. The valid flag is 0 in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_loc | input | LOC_W | Locality index of the access |
| bus_off | input | OFF_W | Byte offset inside the locality window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| loc_change_cap | input | 1 | Advertise locality-change capability |
| engine_done | input | 1 | Execution engine finished (pulse) |
| engine_fatal | input | 1 | Execution engine fatal error (pulse) |
| cmd_state | output | 3 | Current command state code |
| active_valid | output | 1 | A locality is active |
| active_loc | output | LOC_W | Active locality index |

## Verification
The assertions check four properties on every cycle:
- an active locality always has its request bit set;
- the active index only rises, unless the active locality relinquishes;
- the fatal state and the cleared establishment flag never leave;
- completion is only entered from execution or cancel.

The bench scenarios show the properties that depend on exact values: the bit positions of every status word, priority-gated seize and establishment reset, handover to the highest requester, the address and ID values, and the all-ones result for unmapped accesses.

// File: rtl/crb_pkg.sv
package crb_pkg;
  typedef enum logic [2:0] {
    CS_IDLE   = 3'd0,
    CS_READY  = 3'd1,
    CS_RECV   = 3'd2,
    CS_EXEC   = 3'd3,
    CS_DONE   = 3'd4,
    CS_CANCEL = 3'd5,
    CS_FATAL  = 3'd6
  } cmd_state_e;

  localparam logic [31:0] OFF_LSTATE  = 32'h00;
  localparam logic [31:0] OFF_LCTRL   = 32'h08;
  localparam logic [31:0] OFF_LSTS    = 32'h0C;
  localparam logic [31:0] OFF_IFID    = 32'h30;
  localparam logic [31:0] OFF_IFID_HI = 32'h34;
  localparam logic [31:0] OFF_CREQ    = 32'h40;
  localparam logic [31:0] OFF_CSTS    = 32'h44;
  localparam logic [31:0] OFF_CCANCEL = 32'h48;
  localparam logic [31:0] OFF_CSTART  = 32'h4C;
  localparam logic [31:0] OFF_CMDSZ   = 32'h58;
  localparam logic [31:0] OFF_CMDLO   = 32'h5C;
  localparam logic [31:0] OFF_CMDHI   = 32'h60;
  localparam logic [31:0] OFF_RSPSZ   = 32'h64;
  localparam logic [31:0] OFF_RSPLO   = 32'h68;
  localparam logic [31:0] OFF_RSPHI   = 32'h6C;
  localparam logic [31:0] OFF_BUF     = 32'h80;
endpackage

// File: rtl/crb_loc_arb.sv
module crb_loc_arb #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctrl_wr,
  input  logic [LOC_W-1:0]   wr_loc,
  input  logic               req_bit,
  input  logic               rel_bit,
  input  logic               seize_bit,
  output logic               act_valid,
  output logic [LOC_W-1:0]   act_loc,
  output logic [NUM_LOC-1:0] req_map,
  output logic [NUM_LOC-1:0] seized_map
);
  logic [NUM_LOC-1:0] wr_bit;
  logic [NUM_LOC-1:0] remain;
  logic               seize_ok, req_ok, rel_ok;
  logic               nxt_valid;
  logic [LOC_W-1:0]   nxt_loc;

  assign wr_bit   = NUM_LOC'(1) << wr_loc;
  assign seize_ok = ctrl_wr && seize_bit && act_valid && (wr_loc > act_loc);
  assign req_ok   = ctrl_wr && req_bit && ((req_map & wr_bit) == '0);
  assign rel_ok   = ctrl_wr && rel_bit && ((req_map & wr_bit) != '0);
  assign remain   = req_map & ~wr_bit;

  // highest-numbered remaining requester wins the handover
  always_comb begin
    nxt_valid = 1'b0;
    nxt_loc   = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (remain[i]) begin
        nxt_valid = 1'b1;
        nxt_loc   = LOC_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_valid  <= 1'b0;
      act_loc    <= '0;
      req_map    <= '0;
      seized_map <= '0;
    end else if (seize_ok) begin
      seized_map <= seized_map | (NUM_LOC'(1) << act_loc);
      req_map    <= req_map | wr_bit;
      act_loc    <= wr_loc;
    end else if (req_ok) begin
      req_map <= req_map | wr_bit;
      if (!act_valid) begin
        act_valid <= 1'b1;
        act_loc   <= wr_loc;
      end
    end else if (rel_ok) begin
      req_map    <= req_map & ~wr_bit;
      seized_map <= seized_map & ~wr_bit;
      if (act_valid && act_loc == wr_loc) begin
        act_valid <= nxt_valid;
        act_loc   <= nxt_loc;
      end
    end
  end

  // R5
  active_req_chk: assert property (@(posedge clk) disable iff (rst)
    act_valid |-> req_map[act_loc]);

  // R7
  active_mono_chk: assert property (@(posedge clk) disable iff (rst)
    (act_valid && $past(act_valid) && !$past(rel_ok)) |-> (act_loc >= $past(act_loc)));
endmodule

// File: rtl/crb_cmd_fsm.sv
module crb_cmd_fsm
  import crb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       go_ready,
  input  logic       go_idle,
  input  logic       buf_wr,
  input  logic       start_wr,
  input  logic       cancel_wr,
  input  logic       eng_done,
  input  logic       eng_fatal,
  output cmd_state_e st
);
  cmd_state_e nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      CS_IDLE:   if (go_ready) nxt = CS_READY;
      CS_READY:  if (go_idle) nxt = CS_IDLE;
                 else if (start_wr) nxt = CS_EXEC;
                 else if (buf_wr) nxt = CS_RECV;
      CS_RECV:   if (go_idle) nxt = CS_IDLE;
                 else if (start_wr) nxt = CS_EXEC;
      CS_EXEC:   if (eng_done) nxt = CS_DONE;
                 else if (cancel_wr) nxt = CS_CANCEL;
      CS_CANCEL: if (eng_done) nxt = CS_DONE;
      CS_DONE:   if (go_idle) nxt = CS_IDLE;
                 else if (go_ready) nxt = CS_READY;
      default:   nxt = CS_FATAL;
    endcase
    if (eng_fatal) nxt = CS_FATAL;
  end

  always_ff @(posedge clk) begin
    if (rst) st <= CS_IDLE;
    else     st <= nxt;
  end

  // R10
  fatal_hold_chk: assert property (@(posedge clk) disable iff (rst)
    st == CS_FATAL |=> st == CS_FATAL);

  // R9
  done_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (st == CS_DONE && $past(st) != CS_DONE) |-> ($past(st) == CS_EXEC || $past(st) == CS_CANCEL));
endmodule

// File: rtl/crb_reg_view.sv
module crb_reg_view
  import crb_pkg::*;
#(
  parameter int          NUM_LOC   = 5,
  parameter int          LOC_W     = 3,
  parameter logic [63:0] BASE_ADDR = 64'h0000_0001_FED4_0000,
  parameter logic [31:0] WIN_SIZE  = 32'h1000,
  parameter logic [31:0] BUF_BYTES = 32'hF80,
  parameter logic [15:0] VENDOR_ID = 16'h1014,
  parameter logic [15:0] DEVICE_ID = 16'h0001,
  parameter logic [7:0]  REV_ID    = 8'h01
) (
  input  logic [31:0]        off,
  input  logic [LOC_W-1:0]   loc,
  input  logic               act_valid,
  input  logic [LOC_W-1:0]   act_loc,
  input  logic [NUM_LOC-1:0] seized_map,
  input  logic               est_flag,
  input  cmd_state_e         st,
  input  logic               cap_loc,
  output logic [31:0]        word
);
  logic [63:0] buf_addr;
  logic        loc_ok;
  logic [31:0] ifid;

  assign loc_ok   = 32'(loc) < NUM_LOC;
  assign buf_addr = BASE_ADDR + 64'(loc) * 64'(WIN_SIZE) + 64'(OFF_BUF);
  assign ifid     = {REV_ID, 4'b0, 1'b1, 2'b01, 2'b0, 1'b1, 3'b0, 2'b11, cap_loc, 4'h1, 4'h1};

  always_comb begin
    word = '1;
    if (loc_ok) begin
      unique case (off)
        OFF_LSTATE:  word = {24'b0, 1'b1, 2'b0,
                             act_valid ? 3'(act_loc) : 3'b0, act_valid, est_flag};
        OFF_LSTS:    word = {30'b0, seized_map[loc], act_valid && act_loc == loc};
        OFF_IFID:    word = ifid;
        OFF_IFID_HI: word = {DEVICE_ID, VENDOR_ID};
        OFF_LCTRL,
        OFF_CREQ:    word = '0;
        OFF_CSTS:    word = {30'b0, st == CS_IDLE, st == CS_FATAL};
        OFF_CCANCEL: word = {31'b0, st == CS_CANCEL};
        OFF_CSTART:  word = {31'b0, st == CS_EXEC};
        OFF_CMDSZ,
        OFF_RSPSZ:   word = BUF_BYTES;
        OFF_CMDLO,
        OFF_RSPLO:   word = buf_addr[31:0];
        OFF_CMDHI,
        OFF_RSPHI:   word = buf_addr[63:32];
        default:     word = '1;
      endcase
    end
  end
endmodule

// File: rtl/crb_loc_regs.sv
module crb_loc_regs
  import crb_pkg::*;
#(
  parameter int          NUM_LOC   = 5,
  parameter int          OFF_W     = 12,
  parameter logic [63:0] BASE_ADDR = 64'h0000_0001_FED4_0000,
  parameter logic [31:0] WIN_SIZE  = 32'h1000,
  parameter logic [31:0] BUF_BYTES = 32'hF80,
  parameter logic [15:0] VENDOR_ID = 16'h1014,
  parameter logic [15:0] DEVICE_ID = 16'h0001,
  parameter logic [7:0]  REV_ID    = 8'h01,
  localparam int         LOC_W     = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [LOC_W-1:0] bus_loc,
  input  logic [OFF_W-1:0] bus_off,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             bus_rvalid,
  input  logic             loc_change_cap,
  input  logic             engine_done,
  input  logic             engine_fatal,
  output logic [2:0]       cmd_state,
  output logic             active_valid,
  output logic [LOC_W-1:0] active_loc
);
  logic [31:0]        off32;
  logic               wr_ok, from_act, lctrl_wr, est_clr;
  logic               creq_wr, start_wr, cancel_wr, buf_wr;
  logic [NUM_LOC-1:0] req_map, seized_map;
  logic               est_flag;
  cmd_state_e         st;
  logic [31:0]        view_word;

  assign off32     = 32'(bus_off);
  assign wr_ok     = bus_wr && (32'(bus_loc) < NUM_LOC);
  assign from_act  = active_valid && (bus_loc == active_loc);
  assign lctrl_wr  = wr_ok && off32 == OFF_LCTRL;
  assign creq_wr   = wr_ok && from_act && off32 == OFF_CREQ;
  assign start_wr  = wr_ok && from_act && off32 == OFF_CSTART && bus_wdata[0];
  assign cancel_wr = wr_ok && from_act && off32 == OFF_CCANCEL && bus_wdata[0];
  assign buf_wr    = wr_ok && from_act && off32 >= OFF_BUF && off32 < OFF_BUF + BUF_BYTES;
  assign est_clr   = lctrl_wr && bus_wdata[3] && active_valid && 32'(active_loc) >= 3
                     && (st == CS_IDLE || st == CS_READY);

  crb_loc_arb #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_arb (
    .clk, .rst,
    .ctrl_wr   (lctrl_wr),
    .wr_loc    (bus_loc),
    .req_bit   (bus_wdata[0]),
    .rel_bit   (bus_wdata[1]),
    .seize_bit (bus_wdata[2]),
    .act_valid (active_valid),
    .act_loc   (active_loc),
    .req_map   (req_map),
    .seized_map(seized_map)
  );

  crb_cmd_fsm u_fsm (
    .clk, .rst,
    .go_ready (creq_wr && bus_wdata[0]),
    .go_idle  (creq_wr && bus_wdata[1]),
    .buf_wr   (buf_wr),
    .start_wr (start_wr),
    .cancel_wr(cancel_wr),
    .eng_done (engine_done),
    .eng_fatal(engine_fatal),
    .st       (st)
  );

  crb_reg_view #(
    .NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .BASE_ADDR(BASE_ADDR), .WIN_SIZE(WIN_SIZE),
    .BUF_BYTES(BUF_BYTES), .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .REV_ID(REV_ID)
  ) u_view (
    .off       (off32),
    .loc       (bus_loc),
    .act_valid (active_valid),
    .act_loc   (active_loc),
    .seized_map(seized_map),
    .est_flag  (est_flag),
    .st        (st),
    .cap_loc   (loc_change_cap),
    .word      (view_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      est_flag   <= 1'b1;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      if (est_clr) est_flag <= 1'b0;
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= view_word;
    end
  end

  assign cmd_state = st;

  // R3
  est_stays_clr_chk: assert property (@(posedge clk) disable iff (rst)
    !est_flag |=> !est_flag);
endmodule

// File: tb/test_crb_loc_regs.sv
`timescale 1ns/1ps
module test_crb_loc_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_loc = '0;
  logic [11:0] bus_off = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        loc_change_cap = 1'b0;
  logic        engine_done = 1'b0, engine_fatal = 1'b0;
  logic [2:0]  cmd_state;
  logic        active_valid;
  logic [2:0]  active_loc;

  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  crb_loc_regs i_crb_loc_regs (
    .clk, .rst, .bus_rd, .bus_wr, .bus_loc, .bus_off, .bus_wdata,
    .bus_rdata, .bus_rvalid, .loc_change_cap, .engine_done, .engine_fatal,
    .cmd_state, .active_valid, .active_loc
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int loc, input int off, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_loc = 3'(loc); bus_off = 12'(off); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int loc, input int off, input logic [31:0] exp);
    @(negedge clk);
    bus_rd = 1'b1; bus_loc = 3'(loc); bus_off = 12'(off);
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, bus_rdata, exp);
  endtask

  task automatic pulse_done();
    @(negedge clk); engine_done = 1'b1;
    @(negedge clk); engine_done = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", {29'b0, cmd_state}, 32'd0);
    check("R1", {31'b0, active_valid}, 32'd0);
    rd_chk("R1", 0, 'h00, 32'h81);
    rd_chk("R1", 0, 'h0C, 32'h0);
    rd_chk("R1", 0, 'h44, 32'h2);
  endtask

  task automatic t_read_timing();
    @(negedge clk);
    bus_rd = 1'b1; bus_loc = 3'd0; bus_off = 12'h30;
    @(negedge clk);
    bus_rd = 1'b0;
    check("R14", {31'b0, bus_rvalid}, 32'd1);
    @(negedge clk);
    check("R14", {31'b0, bus_rvalid}, 32'd0);
  endtask

  task automatic t_request();
    wr(1, 'h08, 32'h1);
    rd_chk("R2", 0, 'h00, 32'h87);
    rd_chk("R4", 1, 'h0C, 32'h1);
    rd_chk("R4", 0, 'h0C, 32'h0);
    wr(2, 'h08, 32'h1);
    rd_chk("R5", 0, 'h00, 32'h87);
    wr(1, 'h08, 32'h8);
    rd_chk("R3", 0, 'h00, 32'h87);
  endtask

  task automatic t_seize();
    wr(0, 'h08, 32'h4);
    rd_chk("R7", 0, 'h00, 32'h87);
    wr(3, 'h08, 32'h4);
    rd_chk("R7", 0, 'h00, 32'h8F);
    rd_chk("R4", 1, 'h0C, 32'h2);
    rd_chk("R4", 3, 'h0C, 32'h1);
  endtask

  task automatic t_est();
    wr(3, 'h08, 32'h8);
    rd_chk("R3", 0, 'h00, 32'h8E);
  endtask

  task automatic t_relinquish();
    wr(4, 'h08, 32'h2);
    rd_chk("R6", 0, 'h00, 32'h8E);
    wr(3, 'h08, 32'h2);
    rd_chk("R6", 0, 'h00, 32'h8A);
    rd_chk("R6", 1, 'h0C, 32'h2);
    wr(1, 'h08, 32'h2);
    rd_chk("R6", 1, 'h0C, 32'h0);
    rd_chk("R6", 0, 'h00, 32'h8A);
  endtask

  task automatic t_fsm();
    wr(0, 'h40, 32'h1);
    rd_chk("R9", 0, 'h44, 32'h2);
    wr(2, 'h40, 32'h1);
    check("R9", {29'b0, cmd_state}, 32'd1);
    rd_chk("R8", 2, 'h44, 32'h0);
    rd_chk("R13", 2, 'h40, 32'h0);
    wr(2, 'h80, 32'hDEAD);
    check("R9", {29'b0, cmd_state}, 32'd2);
    wr(2, 'h4C, 32'h1);
    check("R9", {29'b0, cmd_state}, 32'd3);
    rd_chk("R8", 2, 'h4C, 32'h1);
    wr(2, 'h48, 32'h1);
    rd_chk("R8", 2, 'h48, 32'h1);
    rd_chk("R8", 2, 'h4C, 32'h0);
    pulse_done();
    check("R9", {29'b0, cmd_state}, 32'd4);
    rd_chk("R8", 2, 'h48, 32'h0);
    wr(2, 'h40, 32'h2);
    rd_chk("R8", 2, 'h44, 32'h2);
    wr(2, 'h40, 32'h1);
    wr(2, 'h4C, 32'h1);
    check("R9", {29'b0, cmd_state}, 32'd3);
    pulse_done();
    check("R9", {29'b0, cmd_state}, 32'd4);
    wr(2, 'h40, 32'h2);
    check("R9", {29'b0, cmd_state}, 32'd0);
  endtask

  task automatic t_addr();
    rd_chk("R11", 2, 'h68, 32'hFED42080);
    rd_chk("R11", 2, 'h6C, 32'h1);
    rd_chk("R11", 2, 'h5C, 32'hFED42080);
    rd_chk("R11", 2, 'h60, 32'h1);
    rd_chk("R11", 0, 'h68, 32'hFED40080);
    rd_chk("R11", 2, 'h64, 32'hF80);
    rd_chk("R11", 2, 'h58, 32'hF80);
  endtask

  task automatic t_ifid();
    loc_change_cap = 1'b0;
    rd_chk("R12", 0, 'h30, 32'h010A4611);
    loc_change_cap = 1'b1;
    rd_chk("R12", 0, 'h30, 32'h010A4711);
    rd_chk("R12", 0, 'h34, 32'h00011014);
  endtask

  task automatic t_unmapped();
    rd_chk("R13", 0, 'h20, 32'hFFFFFFFF);
    rd_chk("R13", 0, 'h08, 32'h0);
    rd_chk("R13", 2, 'h100, 32'hFFFFFFFF);
    rd_chk("R13", 7, 'h00, 32'hFFFFFFFF);
    wr(2, 'h20, 32'hFFFFFFFF);
    wr(7, 'h08, 32'h4);
    rd_chk("R13", 0, 'h00, 32'h8A);
  endtask

  task automatic t_fatal();
    @(negedge clk); engine_fatal = 1'b1;
    @(negedge clk); engine_fatal = 1'b0;
    rd_chk("R10", 2, 'h44, 32'h1);
    wr(2, 'h40, 32'h2);
    rd_chk("R10", 2, 'h44, 32'h1);
    check("R10", {29'b0, cmd_state}, 32'd6);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read_timing();
    t_request();
    t_seize();
    t_est();
    t_relinquish();
    t_fsm();
    t_addr();
    t_ifid();
    t_unmapped();
    t_fatal();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule